// File: doc/BRIEF.md
# Pipelined Single-Deselect Synchronous SRAM Core

This block is a synthesizable behavioural model of a pipelined synchronous static memory. It holds a parameterised number of 36-bit words, and each word is split into four 9-bit byte lanes. On each rising clock edge the block samples the following inputs:

- an address;
- three chip enables;
- byte-lane write controls and a global write;
- write data.

An address generator outside the block supplies the access address each cycle, so burst sequencing is not part of this core.

Read data passes through two registers. The first is the input capture stage. The second is the output register that is loaded from the array. Data is therefore presented one cycle after the read was captured, and back-to-back reads stream one word per cycle. The bus is modelled as a data vector plus a drive-enable flag. The drive-enable is gated asynchronously by an output enable and by a sleep input.

Deselection is one stage shorter than a read. The cycle after a deselect is captured, the drive-enable is already low, even if that cycle would otherwise have carried read data. Sleep stops all new accesses and turns the bus off at once. Stored data is kept through sleep.

Top module: `sram_pipe_scd`

## Requirements
- R1: After synchronous reset, dq_oe is 0 and dq_out is all zeros.
- R2: The device is selected only when ce_n is 0, ce_a is 1 and ce_b is 1. Any other combination captured on an edge is a deselect.
- R3: A selected, non-write, non-sleep cycle captured at edge N is a read. dq_out carries the addressed word after edge N+1. dq_oe is high in that cycle only if oe is 1, sleep is 0 and the command captured at N+1 is not a deselect. dq_oe is never high in a cycle that does not follow such a read.
- R4: A deselect captured at edge N forces dq_oe low for the cycle after edge N. This holds even when a read captured at N-1 would present its data then.
- R5: A byte write needs bw_en=1 and at least one lane_we bit set. Lane i occupies wdata/dq_out bits [9i+8:9i] and is written only when lane_we[i]=1; other lanes keep their contents. A selected cycle with bw_en=0, or with lane_we=0, and gw=0 is a read and writes nothing.
- R6: gw=1 on a selected cycle writes all four lanes, whatever bw_en and lane_we are.
- R7: oe acts without a clock. dq_oe falls as soon as oe is 0 and returns when oe is 1.
- R8: sleep=1 forces dq_oe low at once. A command captured while sleep=1 is ignored, and writes issued then leave memory unchanged. Data stored before sleep reads back after it.
- R9: A write at edge N followed by a read of the same address at N+1 returns the new word. A read captured at N followed by a write to that address at N+1 returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address from the address generator |
| ce_n | input | 1 | Chip enable, active low |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| bw_en | input | 1 | Byte-write enable |
| lane_we | input | 4 | Per-lane write selects |
| gw | input | 1 | Global write of all lanes |
| wdata | input | 36 | Write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request |
| dq_out | output | 36 | Registered read data |
| dq_oe | output | 1 | Bus drive enable for dq_out |

## Verification
The capture-stage flags can go wrong: a stuck read flag or a stuck deselect flag. Either one shows on dq_oe within one or two cycles of the command, because the flag gates the drive directly. A wrong lane mask or a wrong array write stays hidden until that address is read. It then appears on dq_out two edges after the read is issued. For that reason every written lane pattern is read back, and dq_oe and dq_out are compared with a reference on every cycle. Asynchronous effects of oe and sleep are checked between clock edges, with no edge in between.

// File: rtl/sram_pkg.sv
// Shared geometry and command type for the pipelined SRAM core.
package sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             rd;
        logic             desel;
        logic [LANES-1:0] lane_mask;
    } cmd_t;
endpackage

// File: rtl/sram_cmd_decode.sv
// Decodes the sampled control pins into one access command.
// Assumes all inputs are stable at the clock edge. Sleep blocks every command.
module sram_cmd_decode
    import sram_pkg::*;
(
    input  logic             ce_n,
    input  logic             ce_a,
    input  logic             ce_b,
    input  logic             sleep,
    input  logic             bw_en,
    input  logic [LANES-1:0] lane_we,
    input  logic             gw,
    output cmd_t             cmd
);
    logic             sel;
    logic             awake;
    logic [LANES-1:0] mask;
    logic             wr;

    // Select, lane mask and command class.
    always_comb begin
        sel   = !ce_n && ce_a && ce_b;
        awake = !sleep;
        if (gw)
            mask = '1;
        else if (bw_en)
            mask = lane_we;
        else
            mask = '0;
        wr            = sel && awake && (|mask);
        cmd.lane_mask = wr ? mask : '0;
        cmd.rd        = sel && awake && !wr;
        cmd.desel     = !sel && awake;
    end
endmodule

// File: rtl/sram_issue_ctl.sv
// Capture stage and output-valid stage of the read pipeline, plus bus drive.
// A read captured at edge N loads the output register at N+1. A deselect
// held in the capture stage turns the drive off one stage early.
module sram_issue_ctl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rd,
    input  logic              cmd_desel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              oe,
    input  logic              sleep,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              drive
);
    logic s1_rd;
    logic s1_desel;
    logic q_vld;

    // Capture stage: registers the decoded command and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_rd    <= 1'b0;
            s1_desel <= 1'b0;
            rd_addr  <= '0;
        end else begin
            s1_rd    <= cmd_rd;
            s1_desel <= cmd_desel;
            rd_addr  <= addr_in;
        end
    end

    // Output stage: marks the output register as holding fresh read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_vld <= 1'b0;
        else
            q_vld <= s1_rd;
    end

    assign rd_en = s1_rd;
    // Drive: asynchronous oe and sleep gating, plus early deselect cut-off.
    assign drive = oe && !sleep && q_vld && !s1_desel;
endmodule

// File: rtl/sram_lane_array.sv
// Storage split into byte lanes, each with its own array and output register.
// Writes use the address sampled this edge. Reads use the captured address, so
// a read returns the contents from before a write landing on the same edge.
module sram_lane_array
    import sram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        // Lane write port.
        always_ff @(posedge clk) begin
            if (wr_mask[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Lane output register, loaded only by a captured read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (rd_en)
                q <= mem[rd_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/sram_pipe_scd.sv
// Top of the pipelined single-deselect SRAM core.
// Assumes the address comes from an external generator every cycle. Bus
// tristate is represented by dq_out together with dq_oe.
module sram_pipe_scd
    import sram_pkg::*;
#(
    parameter int  DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              bw_en,
    input  logic [3:0]        lane_we,
    input  logic              gw,
    input  logic [35:0]       wdata,
    input  logic              oe,
    input  logic              sleep,
    output logic [35:0]       dq_out,
    output logic              dq_oe
);
    cmd_t              cmd;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;

    sram_cmd_decode u_dec (
        .ce_n    (ce_n),
        .ce_a    (ce_a),
        .ce_b    (ce_b),
        .sleep   (sleep),
        .bw_en   (bw_en),
        .lane_we (lane_we),
        .gw      (gw),
        .cmd     (cmd)
    );

    sram_issue_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_rd    (cmd.rd),
        .cmd_desel (cmd.desel),
        .addr_in   (addr),
        .oe        (oe),
        .sleep     (sleep),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .drive     (dq_oe)
    );

    sram_lane_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (cmd.lane_mask),
        .wr_addr (addr),
        .wr_data (wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (dq_out)
    );
endmodule

// File: rtl/sram_pipe_scd_chk.sv
// Port-level protocol checker for sram_pipe_scd, attached with bind.
// Decodes the commands from the pins on its own and checks when the drive may be high.
module sram_pipe_scd_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              ce_a,
    input logic              ce_b,
    input logic              bw_en,
    input logic [3:0]        lane_we,
    input logic              gw,
    input logic [35:0]       wdata,
    input logic              oe,
    input logic              sleep,
    input logic [35:0]       dq_out,
    input logic              dq_oe
);
    logic       sel_w;
    logic       rd_w;
    logic       desel_w;
    logic [1:0] cyc;

    // Independent command view from the pins.
    assign sel_w   = !ce_n && ce_a && ce_b;
    assign rd_w    = sel_w && !sleep && !(gw || (bw_en && (|lane_we)));
    assign desel_w = !sel_w && !sleep;

    // Edges seen since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc <= '0;
        else if (cyc != 2'd3)
            cyc <= cyc + 2'd1;
    end

    assert_desel_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        desel_w |=> !dq_oe);

    assert_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && $past(rd_w, 2) && !$past(desel_w) && oe && !sleep) |-> dq_oe);

    assert_drive_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cyc >= 2'd2 && $past(rd_w, 2)));

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe);

    assert_sleep_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);
endmodule

bind sram_pipe_scd sram_pipe_scd_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sram_pipe_scd.sv
`timescale 1ns/100ps
module tb_sram_pipe_scd;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        ce_n = 1'b1, ce_a = 1'b1, ce_b = 1'b1;
    logic        bw_en = 1'b0, gw = 1'b0, oe = 1'b1, sleep = 1'b0;
    logic [3:0]  lane_we = '0;
    logic [35:0] wdata = '0;
    logic [35:0] dq_out;
    logic        dq_oe;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";

    sram_pipe_scd #(.DEPTH(DEPTH)) dut (.*);

    always #2.5 clk = ~clk;

    // Behavioural reference model state.
    logic [35:0] m_mem [0:DEPTH-1];
    bit          m_s1_rd, m_s1_desel, m_q_vld;
    int          m_s1_addr;
    logic [35:0] m_q;
    bit          m_sel, m_wr;
    logic [3:0]  m_mask;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1_rd = 0; m_s1_desel = 0; m_q_vld = 0; m_q = '0; m_s1_addr = 0;
        end else begin
            if (m_s1_rd) m_q = m_mem[m_s1_addr];
            m_q_vld = m_s1_rd;
            m_sel  = !ce_n && ce_a && ce_b;
            m_mask = gw ? 4'hF : (bw_en ? lane_we : 4'h0);
            m_wr   = m_sel && !sleep && (m_mask != 0);
            m_s1_rd    = m_sel && !sleep && !m_wr;
            m_s1_desel = !m_sel && !sleep;
            m_s1_addr  = int'(addr);
            if (m_wr)
                for (int l = 0; l < 4; l++)
                    if (m_mask[l]) m_mem[addr][l*9 +: 9] = wdata[l*9 +: 9];
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_oe;
            exp_oe = oe && !sleep && m_q_vld && !m_s1_desel;
            n_tests++;
            if (dq_oe !== exp_oe) begin
                n_fail++;
                $display("FAIL %s model: dq_oe=%b expected %b", phase, dq_oe, exp_oe);
            end
            if (exp_oe) begin
                n_tests++;
                if (dq_out !== m_q) begin
                    n_fail++;
                    $display("FAIL %s model: dq_out=%h expected %h", phase, dq_out, m_q);
                end
            end
        end
    end

    function automatic logic [35:0] pat(input int a);
        return {9'(a + 64), 9'(a * 3 + 1), 9'(a ^ 9'h1AA), 9'(a + 256)};
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic cn, input logic ca, input logic cb, input int a,
                        input logic bw, input logic [3:0] lw, input logic g,
                        input logic [35:0] d);
        ce_n = cn; ce_a = ca; ce_b = cb; addr = 8'(a);
        bw_en = bw; lane_we = lw; gw = g; wdata = d;
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input int a);
        step(1'b0, 1'b1, 1'b1, a, 1'b0, 4'h0, 1'b0, '0);
    endtask

    task automatic gwr(input int a, input logic [35:0] d);
        step(1'b0, 1'b1, 1'b1, a, 1'b0, 4'h0, 1'b1, d);
    endtask

    initial begin
        #(50000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state
        chk("R1 dq_oe", {35'd0, dq_oe}, 36'd0);
        chk("R1 dq_out", dq_out, 36'd0);

        // R6: global writes, including one with byte controls also set
        phase = "R6";
        for (int a = 0; a < 8; a++) gwr(a, pat(a));
        step(1'b0, 1'b1, 1'b1, 8, 1'b1, 4'b0001, 1'b1, pat(8));

        // R3: read latency and streaming
        phase = "R3";
        rd(0);
        chk("R3 no drive first cycle", {35'd0, dq_oe}, 36'd0);
        for (int a = 1; a <= 8; a++) begin
            rd(a);
            chk("R3 drive", {35'd0, dq_oe}, 36'd1);
            chk("R3 data", dq_out, pat(a - 1));
        end
        rd(0);
        chk("R6 all lanes written", dq_out, pat(8));

        // R5: byte lane writes and non-writes
        phase = "R5";
        step(1'b0, 1'b1, 1'b1, 2, 1'b1, 4'b0101, 1'b0, 36'hF_FFFF_FFFF);
        step(1'b0, 1'b1, 1'b1, 2, 1'b1, 4'b0000, 1'b0, 36'hF_FFFF_FFFF);
        step(1'b0, 1'b1, 1'b1, 3, 1'b0, 4'b1111, 1'b0, 36'd0);
        chk("R5 lanes 0,2 only", dq_out, pat(2) | 36'h0_07FC_01FF);
        rd(3);
        chk("R5 no write without bw_en", dq_out, pat(3));

        // R4: early deselect cut-off
        phase = "R4";
        rd(1);
        step(1'b1, 1'b1, 1'b1, 0, 1'b0, 4'h0, 1'b0, '0);
        chk("R4 off after deselect", {35'd0, dq_oe}, 36'd0);
        rd(4);
        chk("R4 still off", {35'd0, dq_oe}, 36'd0);
        rd(5);
        chk("R4 resumes", dq_out, pat(4));

        // R2: each chip enable alone deselects
        phase = "R2";
        step(1'b0, 1'b0, 1'b1, 0, 1'b0, 4'h0, 1'b0, '0);
        chk("R2 ce_a low", {35'd0, dq_oe}, 36'd0);
        rd(6); rd(6);
        chk("R2 selected", dq_out, pat(6));
        step(1'b0, 1'b1, 1'b0, 0, 1'b0, 4'h0, 1'b0, '0);
        chk("R2 ce_b low", {35'd0, dq_oe}, 36'd0);
        rd(7); rd(7);
        chk("R2 selected again", dq_out, pat(7));
        step(1'b1, 1'b1, 1'b1, 7, 1'b0, 4'h0, 1'b1, 36'd0);
        chk("R2 ce_n high", {35'd0, dq_oe}, 36'd0);
        rd(7); rd(7);
        chk("R2 no write when deselected", dq_out, pat(7));

        // R9: write/read ordering on the same address
        phase = "R9";
        gwr(5, 36'h1_2345_6789);
        rd(5); rd(5);
        chk("R9 read after write", dq_out, 36'h1_2345_6789);
        rd(6);
        gwr(6, 36'h0_ABCD_0123);
        chk("R9 read before write", dq_out, pat(6));
        rd(6); rd(6);
        chk("R9 new value", dq_out, 36'h0_ABCD_0123);

        // R7: asynchronous output enable
        phase = "R7";
        rd(1); rd(2);
        oe = 1'b0; #0.2;
        chk("R7 oe low", {35'd0, dq_oe}, 36'd0);
        oe = 1'b1; #0.2;
        chk("R7 oe high", {35'd0, dq_oe}, 36'd1);
        chk("R7 data", dq_out, pat(1));

        // R8: sleep gating, ignored commands, retention
        phase = "R8";
        rd(3);
        sleep = 1'b1; #0.2;
        chk("R8 sleep off", {35'd0, dq_oe}, 36'd0);
        gwr(0, 36'hF_0F0F_0F0F);
        chk("R8 off in sleep", {35'd0, dq_oe}, 36'd0);
        rd(3);
        sleep = 1'b0;
        rd(0);
        chk("R8 nothing pending", {35'd0, dq_oe}, 36'd0);
        rd(0);
        chk("R8 retained", dq_out, pat(0));

        phase = "end";
        step(1'b1, 1'b1, 1'b1, 0, 1'b0, 4'h0, 1'b0, '0);
        @(negedge clk); #1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule